// File: doc/BRIEF.md
# SMBus Register Access Bridge Sequencer

This block sits behind an SMBus slave byte engine. It turns a series of SMBus write transactions into a single read or write on an internal bus. The engine hands over each write as three kinds of event: a command byte, zero or more data bytes, and a done strobe. The done strobe marks the point where the engine needs an acknowledge decision for that write.

Each command byte carries four things: an End flag, a configuration/memory select, a read/write select and a starting parameter index. Each data byte after it goes to the parameter slot at the current index, and the index then moves up by one. This lets byte, word and block writes load the parameters in any mix. The parameters are:

- for a configuration access, a bus number, a device/function number and a 12-bit register number;
- for a memory access, a 19-bit offset that lands in a 512 KB window above a programmable base;
- for a write, up to four data bytes.

A write whose command has the End flag set launches the internal request. The block then holds the SMBus clock stretched until the internal response arrives, and it answers that final write with ACK or NACK according to the response status. Read data is captured into a buffer, which a later SMBus read drains least-significant byte first.

Top module: `smb_reg_bridge`

## Requirements
- R1: After reset, ackValid, stretch, reqValid and rdValid are all 0.
- R2: In a configuration access (command bit 6 = 1), reqCfg is 1 and reqAddr = {slot0 bus, slot1 devfn, 4'h0, slot3[3:0], slot2}. The upper nibble of slot3 has no effect.
- R3: In a memory access (command bit 6 = 0), reqCfg is 0 and reqAddr = {memBase[31:19], slot6[2:0], slot5, slot4}. Slot6 bits 7:3 and slot7 have no effect.
- R4: Command bits 4:0 set the slot index. Each data byte is stored at the current index, and the index then increments. Slots keep their contents across writes, so parameters can be spread over several writes.
- R5: A write without the End flag (command bit 7 = 0) is acknowledged one cycle after wrDone, with ackNack = 0, and no request is issued.
- R6: A write with the End flag raises reqValid for exactly one cycle, one cycle after wrDone. reqWrite is the inverse of command bit 5 (1 = read), and reqWdata = {slot11, slot10, slot9, slot8}.
- R7: stretch rises together with reqValid and stays high until the cycle after respValid. It falls in the same cycle that ackValid pulses.
- R8: The final write's acknowledge carries ackNack = respErr.
- R9: A successful read response is captured. rdValid then goes to 1, and rdByte returns bytes least-significant first. Each rdNext advances to the next byte, wrapping after the fourth.
- R10: A command whose read/write bit differs from the one latched earlier in the open sequence does three things: it clears all slots, it ignores the data bytes of that write, and it is answered with NACK. It issues no request even when its End flag is set.
- R11: A command byte that opens a new sequence clears rdValid one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte: bit 7 End, bit 6 config, bit 5 read, bits 4:0 start index |
| dataValid | input | 1 | Data byte strobe |
| dataByte | input | 8 | Data byte |
| wrDone | input | 1 | Write transaction finished; acknowledge requested |
| ackValid | output | 1 | Acknowledge decision pulse |
| ackNack | output | 1 | 1 = NACK, 0 = ACK |
| stretch | output | 1 | Clock stretch request |
| rdNext | input | 1 | Advance read buffer byte pointer |
| rdByte | output | 8 | Current read buffer byte |
| rdValid | output | 1 | Read buffer holds valid data |
| memBase | input | 32 | Base register for memory accesses |
| reqValid | output | 1 | Internal request pulse |
| reqWrite | output | 1 | Internal request is a write |
| reqCfg | output | 1 | Internal request is a configuration access |
| reqAddr | output | 32 | Internal request address |
| reqWdata | output | 32 | Internal write data |
| respValid | input | 1 | Internal response strobe |
| respErr | input | 1 | Internal response error (address error or abort) |
| respRdata | input | 32 | Internal read data |

## Verification
Every result is registered once. An acknowledge for a write without End, and the request pulse for a write with End, therefore appear one cycle after wrDone. The final acknowledge, the drop of stretch and the buffer load appear one cycle after respValid. A cleared rdValid appears one cycle after the opening command byte. The bench drives inputs on falling edges and samples on the next falling edge, so each check lands half a period after the rising edge that should have produced the result. While the response is withheld, stretch and the absence of further request pulses are sampled on every cycle.

// File: rtl/smb_reg_bridge_pkg.sv
package smb_reg_bridge_pkg;

  // command byte field positions
  localparam int CMD_END_BIT = 7;
  localparam int CMD_CFG_BIT = 6;
  localparam int CMD_RD_BIT  = 5;
  localparam int CMD_IDX_W   = 5;

  // parameter slot map
  localparam int SLOT_BUS    = 0;
  localparam int SLOT_DEVFN  = 1;
  localparam int SLOT_REG_LO = 2;
  localparam int SLOT_REG_HI = 3;
  localparam int SLOT_ADDR0  = 4;
  localparam int SLOT_ADDR1  = 5;
  localparam int SLOT_ADDR2  = 6;
  localparam int SLOT_ADDR3  = 7;
  localparam int SLOT_DATA0  = 8;

  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_e;

  typedef struct packed {
    logic latchCmd;
    logic writeByte;
    logic clrParams;
    logic loadBuf;
    logic clrBuf;
  } dpStrobe_t;

endpackage

// File: rtl/smb_reg_bridge_dp.sv
module smb_reg_bridge_dp
  import smb_reg_bridge_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int OFFSET_W   = 19,
  parameter int ADDR_W     = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               stb,
  input  logic [7:0]              cmdByte,
  input  logic [7:0]              dataByte,
  input  logic                    rdNext,
  input  logic [ADDR_W-1:0]       memBase,
  input  logic [8*DATA_BYTES-1:0] respRdata,
  output logic                    cmdEnd,
  output logic                    cmdRd,
  output logic                    reqCfg,
  output logic [ADDR_W-1:0]       reqAddr,
  output logic [8*DATA_BYTES-1:0] reqWdata,
  output logic [7:0]              rdByte,
  output logic                    rdValid
);

  localparam int NUM_SLOTS = SLOT_DATA0 + DATA_BYTES;
  localparam int PTR_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam int REG_NUM_W = 12;
  localparam int CFG_PAD_W = ADDR_W - 16 - REG_NUM_W;

  logic [7:0]            slots [NUM_SLOTS];
  logic [CMD_IDX_W-1:0]  idx;
  logic [8*DATA_BYTES-1:0] rdBuf;
  logic [PTR_W-1:0]      rdPtr;

  // parameter slots and index pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= '0;
      idx    <= '0;
      cmdEnd <= 1'b0;
      cmdRd  <= 1'b0;
      reqCfg <= 1'b0;
    end else begin
      if (stb.clrParams) begin
        for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= '0;
      end
      if (stb.latchCmd) begin
        idx    <= cmdByte[CMD_IDX_W-1:0];
        cmdEnd <= cmdByte[CMD_END_BIT];
        cmdRd  <= cmdByte[CMD_RD_BIT];
        reqCfg <= cmdByte[CMD_CFG_BIT];
      end else if (stb.writeByte) begin
        if (int'(idx) < NUM_SLOTS) slots[int'(idx)] <= dataByte;
        if (idx != '1) idx <= idx + 1'b1;
      end
    end
  end

  // address formation
  logic [23:0]         offsetRaw;
  logic [ADDR_W-1:0]   cfgAddr;
  logic [ADDR_W-1:0]   memAddr;

  assign offsetRaw = {slots[SLOT_ADDR2], slots[SLOT_ADDR1], slots[SLOT_ADDR0]};
  assign cfgAddr   = {slots[SLOT_BUS], slots[SLOT_DEVFN], {CFG_PAD_W{1'b0}},
                      slots[SLOT_REG_HI][3:0], slots[SLOT_REG_LO]};
  assign memAddr   = {memBase[ADDR_W-1:OFFSET_W], offsetRaw[OFFSET_W-1:0]};
  assign reqAddr   = reqCfg ? cfgAddr : memAddr;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_wdata
    assign reqWdata[8*g +: 8] = slots[SLOT_DATA0 + g];
  end

  // read buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBuf   <= '0;
      rdPtr   <= '0;
      rdValid <= 1'b0;
    end else if (stb.loadBuf) begin
      rdBuf   <= respRdata;
      rdPtr   <= '0;
      rdValid <= 1'b1;
    end else if (stb.clrBuf) begin
      rdValid <= 1'b0;
      rdPtr   <= '0;
    end else if (rdNext && rdValid) begin
      rdPtr <= (int'(rdPtr) == DATA_BYTES - 1) ? '0 : rdPtr + 1'b1;
    end
  end

  assign rdByte = rdBuf[{rdPtr, 3'b000} +: 8];

  logic unusedBits;
  assign unusedBits = ^{slots[SLOT_ADDR3], offsetRaw, memBase[OFFSET_W-1:0],
                        slots[SLOT_REG_HI][7:4]};

endmodule

// File: rtl/smb_reg_bridge_ctrl.sv
module smb_reg_bridge_ctrl
  import smb_reg_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdRdBit,
  input  logic      dataValid,
  input  logic      wrDone,
  input  logic      cmdEnd,
  input  logic      cmdRd,
  input  logic      respValid,
  input  logic      respErr,
  output dpStrobe_t stb,
  output logic      ackValid,
  output logic      ackNack,
  output logic      stretch,
  output logic      reqValid
);

  ctrlState_e state;
  logic       seqActive;
  logic       seqRd;
  logic       badWrite;
  logic       mismatch;
  logic       isIdle;

  assign isIdle   = (state == ST_IDLE);
  assign mismatch = isIdle && cmdValid && seqActive && (cmdRdBit != seqRd);

  always_comb begin
    stb           = '0;
    stb.latchCmd  = isIdle && cmdValid;
    stb.clrParams = mismatch;
    stb.clrBuf    = isIdle && cmdValid && !seqActive;
    stb.writeByte = isIdle && dataValid && !badWrite;
    stb.loadBuf   = !isIdle && respValid && !respErr && cmdRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      seqActive <= 1'b0;
      seqRd     <= 1'b0;
      badWrite  <= 1'b0;
      ackValid  <= 1'b0;
      ackNack   <= 1'b0;
      stretch   <= 1'b0;
      reqValid  <= 1'b0;
    end else begin
      ackValid <= 1'b0;
      reqValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            if (mismatch) begin
              seqActive <= 1'b0;
              badWrite  <= 1'b1;
            end else begin
              seqActive <= 1'b1;
              seqRd     <= cmdRdBit;
            end
          end
          if (wrDone) begin
            if (badWrite) begin
              ackValid <= 1'b1;
              ackNack  <= 1'b1;
              badWrite <= 1'b0;
            end else if (cmdEnd) begin
              reqValid <= 1'b1;
              stretch  <= 1'b1;
              state    <= ST_WAIT;
            end else begin
              ackValid <= 1'b1;
              ackNack  <= 1'b0;
            end
          end
        end
        ST_WAIT: begin
          if (respValid) begin
            stretch   <= 1'b0;
            ackValid  <= 1'b1;
            ackNack   <= respErr;
            seqActive <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/smb_reg_bridge.sv
module smb_reg_bridge
  import smb_reg_bridge_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int OFFSET_W   = 19,
  parameter int ADDR_W     = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [7:0]              cmdByte,
  input  logic                    dataValid,
  input  logic [7:0]              dataByte,
  input  logic                    wrDone,
  output logic                    ackValid,
  output logic                    ackNack,
  output logic                    stretch,
  input  logic                    rdNext,
  output logic [7:0]              rdByte,
  output logic                    rdValid,
  input  logic [ADDR_W-1:0]       memBase,
  output logic                    reqValid,
  output logic                    reqWrite,
  output logic                    reqCfg,
  output logic [ADDR_W-1:0]       reqAddr,
  output logic [8*DATA_BYTES-1:0] reqWdata,
  input  logic                    respValid,
  input  logic                    respErr,
  input  logic [8*DATA_BYTES-1:0] respRdata
);

  dpStrobe_t stb;
  logic      cmdEnd;
  logic      cmdRd;

  smb_reg_bridge_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdRdBit  (cmdByte[CMD_RD_BIT]),
    .dataValid (dataValid),
    .wrDone    (wrDone),
    .cmdEnd    (cmdEnd),
    .cmdRd     (cmdRd),
    .respValid (respValid),
    .respErr   (respErr),
    .stb       (stb),
    .ackValid  (ackValid),
    .ackNack   (ackNack),
    .stretch   (stretch),
    .reqValid  (reqValid)
  );

  smb_reg_bridge_dp #(
    .DATA_BYTES (DATA_BYTES),
    .OFFSET_W   (OFFSET_W),
    .ADDR_W     (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdByte   (cmdByte),
    .dataByte  (dataByte),
    .rdNext    (rdNext),
    .memBase   (memBase),
    .respRdata (respRdata),
    .cmdEnd    (cmdEnd),
    .cmdRd     (cmdRd),
    .reqCfg    (reqCfg),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .rdByte    (rdByte),
    .rdValid   (rdValid)
  );

  assign reqWrite = !cmdRd;

endmodule

// File: rtl/smb_reg_bridge_chk.sv
module smb_reg_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic ackValid,
  input logic ackNack,
  input logic stretch,
  input logic reqValid,
  input logic reqWrite,
  input logic rdValid,
  input logic respValid,
  input logic respErr
);

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  p_stretch_with_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> stretch);

  p_no_ack_while_stretch_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> !stretch);

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

  p_err_gives_nack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stretch && respValid && respErr) |=> (ackValid && ackNack));

  p_ok_gives_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stretch && respValid && !respErr) |=> (ackValid && !ackNack && !stretch));

  p_read_fills_buf_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stretch && respValid && !respErr && !reqWrite) |=> rdValid);

endmodule

bind smb_reg_bridge smb_reg_bridge_chk u_chk (.*);

// File: tb/smb_reg_bridge_tb.sv
`timescale 1ns/1ps
module smb_reg_bridge_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic        dataValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic        wrDone = 1'b0;
  logic        ackValid, ackNack, stretch;
  logic        rdNext = 1'b0;
  logic [7:0]  rdByte;
  logic        rdValid;
  logic [31:0] memBase = 32'hFFE8_0000;
  logic        reqValid, reqWrite, reqCfg;
  logic [31:0] reqAddr, reqWdata;
  logic        respValid = 1'b0;
  logic        respErr = 1'b0;
  logic [31:0] respRdata = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  smb_reg_bridge u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataValid(dataValid), .dataByte(dataByte), .wrDone(wrDone),
    .ackValid(ackValid), .ackNack(ackNack), .stretch(stretch),
    .rdNext(rdNext), .rdByte(rdByte), .rdValid(rdValid), .memBase(memBase),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqCfg(reqCfg),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .respValid(respValid),
    .respErr(respErr), .respRdata(respRdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one SMBus write: command, n data bytes (LSB of data first), done
  task automatic sendWrite(input logic [7:0] cmd, input logic [31:0] data, input int n);
    @(negedge clk);
    cmdValid = 1'b1; cmdByte = cmd;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      dataValid = 1'b1; dataByte = data[8*i +: 8];
      @(negedge clk);
    end
    dataValid = 1'b0;
    wrDone = 1'b1;
    @(negedge clk);
    wrDone = 1'b0;
  endtask

  task automatic plainAck(input string req);
    check(req, "ackValid", {31'b0, ackValid}, 32'd1);
    check(req, "ackNack", {31'b0, ackNack}, 32'd0);
    check(req, "reqValid", {31'b0, reqValid}, 32'd0);
  endtask

  task automatic respond(input logic err, input logic [31:0] rdata);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", "stretch held", {31'b0, stretch}, 32'd1);
      check("R6", "req single pulse", {31'b0, reqValid}, 32'd0);
    end
    respValid = 1'b1; respErr = err; respRdata = rdata;
    @(negedge clk);
    respValid = 1'b0; respErr = 1'b0;
    check("R7", "stretch released", {31'b0, stretch}, 32'd0);
    check("R8", "final ackValid", {31'b0, ackValid}, 32'd1);
    check("R8", "final ackNack", {31'b0, ackNack}, {31'b0, err});
  endtask

  task automatic testReset;
    check("R1", "ackValid", {31'b0, ackValid}, 32'd0);
    check("R1", "stretch", {31'b0, stretch}, 32'd0);
    check("R1", "reqValid", {31'b0, reqValid}, 32'd0);
    check("R1", "rdValid", {31'b0, rdValid}, 32'd0);
  endtask

  // config read split over two byte-pair writes
  task automatic testCfgRead;
    sendWrite(8'h60, 32'h0000_3412, 2);
    plainAck("R5");
    sendWrite(8'hE2, 32'h0000_AB56, 2);
    check("R6", "reqValid", {31'b0, reqValid}, 32'd1);
    check("R7", "stretch on req", {31'b0, stretch}, 32'd1);
    check("R6", "reqWrite", {31'b0, reqWrite}, 32'd0);
    check("R2", "reqCfg", {31'b0, reqCfg}, 32'd1);
    check("R2", "cfg addr", reqAddr, 32'h1234_0B56);
    check("R4", "no ack before resp", {31'b0, ackValid}, 32'd0);
    respond(1'b0, 32'hDDCC_BBAA);
    check("R9", "rdValid", {31'b0, rdValid}, 32'd1);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] expB;
      expB = 8'hAA + 8'h11 * 8'(k % 4);
      check("R9", "rdByte", {24'b0, rdByte}, {24'b0, expB});
      rdNext = 1'b1;
      @(negedge clk);
      rdNext = 1'b0;
    end
  endtask

  // memory write, error response
  task automatic testMemWrite;
    logic [31:0] expAddr;
    @(negedge clk);
    cmdValid = 1'b1; cmdByte = 8'h04;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R11", "rdValid cleared", {31'b0, rdValid}, 32'd0);
    dataValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      dataByte = (i == 0) ? 8'h11 : (i == 1) ? 8'h22 : (i == 2) ? 8'hFF : 8'h99;
      @(negedge clk);
    end
    dataValid = 1'b0;
    wrDone = 1'b1;
    @(negedge clk);
    wrDone = 1'b0;
    plainAck("R5");
    sendWrite(8'h88, 32'h0102_0304, 4);
    expAddr = (memBase & 32'hFFF8_0000) | 32'h0007_2211;
    check("R6", "reqValid", {31'b0, reqValid}, 32'd1);
    check("R6", "reqWrite", {31'b0, reqWrite}, 32'd1);
    check("R6", "reqWdata", reqWdata, 32'h0102_0304);
    check("R3", "reqCfg", {31'b0, reqCfg}, 32'd0);
    check("R3", "mem addr", reqAddr, expAddr);
    respond(1'b1, 32'h0);
    check("R9", "no buffer on write", {31'b0, rdValid}, 32'd0);
  endtask

  // read/write mismatch clears slots and is refused
  task automatic testMismatch;
    sendWrite(8'h60, 32'h0000_3412, 2);
    plainAck("R5");
    sendWrite(8'hC2, 32'h0000_7777, 2);
    check("R10", "ackValid", {31'b0, ackValid}, 32'd1);
    check("R10", "ackNack", {31'b0, ackNack}, 32'd1);
    check("R10", "no req", {31'b0, reqValid}, 32'd0);
    @(negedge clk);
    check("R10", "no stretch", {31'b0, stretch}, 32'd0);
    check("R10", "still no req", {31'b0, reqValid}, 32'd0);
    sendWrite(8'hE2, 32'h0000_0578, 2);
    check("R10", "slots cleared", reqAddr, 32'h0000_0578);
    respond(1'b0, 32'h1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCfgRead();
    testMemWrite();
    testMismatch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule